// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block decodes the upper address bits of each bus access against eight independently configured chip-select channels. Every channel holds a base value, a mask and a control word. When an access starts and a valid channel matches, the block drives that channel's active-low select. For a read it also drives an active-low output enable. It then counts the channel's wait states, or it waits for an external acknowledge, and ends the access with a one-cycle transfer acknowledge. A write that hits a write-protected channel asserts no select and instead returns a one-cycle access error.

Channel 0 leaves reset valid and matches every address, so boot memory can sit behind it. Its port size comes from two strap inputs, captured on the first clock after reset when the reset-configuration input is high. A small register port with a write strobe and a combinational read configures all channels.

Top module: `csel_ctrl`

## Requirements
- R1: Register port: `reg_sel` 0 selects base, 1 selects mask and 2 selects control for channel `reg_ch`. Base and mask read back in bits 31:16 with zeros below. Control reads back zero-extended with valid in bit 0, write-protect in bit 1, port size in bits 3:2, wait count in bits 7:4 and external termination in bit 8.
- R2: A channel matches when it is valid and `bus_addr[31:16]` equals its base in every bit where its mask bit is 0. Mask bits set to 1 exclude that address bit from the compare.
- R3: When several valid channels match, only the lowest-numbered one is selected, and at most one `cs_n` bit is ever low.
- R4: A write that selects a write-protected channel leaves every `cs_n` high and raises `aerr` for exactly the one cycle after the start cycle, with no `ta`.
- R5: After reset all selects and `oe_n` are high and `ta` and `aerr` are low. Channel 0 is valid with mask 0xFFFF and wait count 15 under internal termination. Every other control word reads 0.
- R6: If `cfg_en` is high on the first clock after reset, channel 0's port size takes `strap_ps`. Otherwise it stays 00.
- R7: `oe_n` goes low only for a read that selects a channel, and it follows that channel's select.
- R8: With internal termination and wait count W, `ta` is high for one cycle, in the (W+1)th cycle after the start cycle. The select is released in that same cycle.
- R9: With external termination, the select stays asserted until `ext_ack` is sampled high. `ta` follows in the next cycle.
- R10: An access that matches no valid channel asserts no select and no output enable, and it raises neither `ta` nor `aerr`.
- R11: `cs_n` and `oe_n` change only on the falling clock edge. They assert half a cycle after the start is sampled.
- R12: `act_ps` gives the port size of the selected channel once the select asserts. The encoding is 00 for 32-bit, 01 for 8-bit, and 10 or 11 for 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Reset-configuration enable for strap capture |
| strap_ps | input | 2 | Strapped port size for channel 0 |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel index for register access |
| reg_sel | input | 2 | Register select: 0 base, 1 mask, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_start | input | 1 | One-cycle access start strobe |
| bus_addr | input | 32 | Access address |
| bus_rd | input | 1 | 1 for read, 0 for write |
| ext_ack | input | 1 | External termination acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| ta | output | 1 | Transfer acknowledge pulse |
| aerr | output | 1 | Access error pulse on protected write |
| act_ps | output | 2 | Port size of the selected channel |

## Verification
Each result has its own due time, counted from the rising edge that samples `bus_start`. `aerr` and the decode are due right after that edge. `cs_n` and `oe_n` are due after the following falling edge, and the bench confirms they are still high just after the sampling rising edge. `ta` is due W+1 cycles later, or one cycle after `ext_ack` is sampled. The bench drives on falling edges and samples one time unit after a falling edge, so every check lands after the edge it depends on. It checks `ta` low in each waiting cycle and high in exactly the due cycle.

// File: rtl/csel_ctrl.sv
module csel_ctrl #(
  parameter int NCH = 8,
  parameter int WSW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        strap_ps,
  input  logic              reg_we,
  input  logic [$clog2(NCH)-1:0] reg_ch,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_start,
  input  logic [31:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              ext_ack,
  output logic [NCH-1:0]    cs_n,
  output logic              oe_n,
  output logic              ta,
  output logic              aerr,
  output logic [1:0]        act_ps
);
  localparam int CHW   = $clog2(NCH);
  localparam int P_V   = 0;
  localparam int P_WP  = 1;
  localparam int P_PS  = 2;
  localparam int P_WS  = 4;
  localparam int P_EXT = P_WS + WSW;
  localparam int CW    = P_EXT + 1;

  logic [15:0]   base_q [NCH];
  logic [15:0]   mask_q [NCH];
  logic [CW-1:0] ctrl_q [NCH];
  logic          boot_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        ctrl_q[i] <= '0;
      end
      mask_q[0]              <= '1;
      ctrl_q[0][P_V]         <= 1'b1;
      ctrl_q[0][P_WS +: WSW] <= '1;
      boot_arm               <= 1'b1;
    end else begin
      boot_arm <= 1'b0;
      if (boot_arm && cfg_en) ctrl_q[0][P_PS +: 2] <= strap_ps;
      if (reg_we) begin
        case (reg_sel)
          2'd0:    base_q[reg_ch] <= reg_wdata[31:16];
          2'd1:    mask_q[reg_ch] <= reg_wdata[31:16];
          2'd2:    ctrl_q[reg_ch] <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {base_q[reg_ch], 16'h0};
      2'd1:    reg_rdata = {mask_q[reg_ch], 16'h0};
      2'd2:    reg_rdata = 32'(ctrl_q[reg_ch]);
      default: reg_rdata = '0;
    endcase
  end

  logic [NCH-1:0] hit;
  logic [CHW-1:0] sel;
  logic [CW-1:0]  sel_ctrl;
  wire            hit_any = |hit;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      hit[i] = ctrl_q[i][P_V] && (((bus_addr[31:16] ^ base_q[i]) & ~mask_q[i]) == 16'h0);
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hit[i]) sel = CHW'(i);
  end
  assign sel_ctrl = ctrl_q[sel];

  logic           busy, cur_rd, cur_ext;
  logic [CHW-1:0] cur;
  logic [WSW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_rd <= 1'b0; cur_ext <= 1'b0; cur <= '0; cnt <= '0;
      ta <= 1'b0; aerr <= 1'b0; act_ps <= 2'b00;
    end else begin
      ta   <= 1'b0;
      aerr <= 1'b0;
      if (!busy) begin
        if (bus_start && hit_any) begin
          if (!bus_rd && sel_ctrl[P_WP]) aerr <= 1'b1;
          else begin
            busy    <= 1'b1;
            cur     <= sel;
            cur_rd  <= bus_rd;
            cur_ext <= sel_ctrl[P_EXT];
            cnt     <= sel_ctrl[P_WS +: WSW];
            act_ps  <= sel_ctrl[P_PS +: 2];
          end
        end
      end else if (cur_ext ? ext_ack : (cnt == '0)) begin
        busy <= 1'b0;
        ta   <= 1'b1;
      end else if (!cur_ext) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= '1;
      oe_n <= 1'b1;
    end else begin
      cs_n <= busy ? ~(NCH'(1) << cur) : '1;
      oe_n <= ~(busy & cur_rd);
    end
  end
endmodule

// File: rtl/csel_ctrl_chk.sv
module csel_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_start,
  input logic [NCH-1:0] cs_n,
  input logic           oe_n,
  input logic           ta,
  input logic           aerr
);
  AST_CS_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R3
  AST_OE_WITH_CS:  assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !(&cs_n)); // R7
  AST_AERR_NO_CS:  assert property (@(posedge clk) disable iff (!rst_n) aerr |-> (&cs_n)); // R4
  AST_AERR_START:  assert property (@(posedge clk) disable iff (!rst_n) aerr |-> $past(bus_start)); // R4
  AST_TA_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) ta |=> !ta); // R8
  AST_TA_NO_AERR:  assert property (@(posedge clk) disable iff (!rst_n) !(ta && aerr)); // R10
endmodule

bind csel_ctrl csel_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start),
  .cs_n(cs_n), .oe_n(oe_n), .ta(ta), .aerr(aerr)
);

// File: tb/csel_ctrl_tb.sv
module csel_ctrl_tb_top;
  logic clk = 0, rst_n = 0, cfg_en = 1;
  logic [1:0] strap_ps = 2'b10;
  logic reg_we = 0;
  logic [2:0] reg_ch = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic bus_start = 0, bus_rd = 0, ext_ack = 0;
  logic [31:0] bus_addr = 0;
  logic [7:0] cs_n;
  logic oe_n, ta, aerr;
  logic [1:0] act_ps;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  csel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .strap_ps(strap_ps),
    .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .ext_ack(ext_ack), .cs_n(cs_n), .oe_n(oe_n), .ta(ta),
    .aerr(aerr), .act_ps(act_ps)
  );

  // Channel setup used by the vector table: wait count and port size
  localparam int CH_W  [8] = '{2, 1, 0, 0, 0, 0, 0, 0};
  localparam int CH_PS [8] = '{1, 2, 3, 0, 0, 0, 0, 0};

  localparam int NV = 9;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0012_3456, 32'h1005_0000, 32'h1005_0000,
    32'h1020_0000, 32'h1020_0000, 32'h3000_0000, 32'h4000_0000, 32'h0100_0000, 32'h00FF_FFFC};
  localparam bit V_RD   [NV] = '{1, 1, 0, 0, 1, 1, 1, 1, 0};
  localparam int V_CH   [NV] = '{0, 1, 8, 2, 2, 8, 8, 8, 0};
  localparam bit V_AERR [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit v, input bit wp, input int ps,
                                          input int w, input bit ext);
    return {23'h0, ext, 4'(w), 2'(ps), wp, v};
  endfunction

  task automatic wr_reg(input int ch, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_ch = 3'(ch); reg_sel = 2'(s); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_reg(input int ch, input int s, input logic [31:0] exp, input string req);
    reg_ch = 3'(ch); reg_sel = 2'(s); #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input bit rd, input int ch, input bit exp_aerr,
                        input int w, input bit ext, input int ps, input string req);
    logic [7:0] exp_cs;
    exp_cs = (ch < 8) ? ~(8'h01 << ch) : 8'hFF;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_start = 1;
    @(posedge clk); #1;
    bus_start = 0;
    chk({req, " R11 cs before fall"}, cs_n, 8'hFF);
    @(negedge clk); #1;
    chk({req, " cs_n"}, cs_n, exp_cs);
    chk({req, " R7 oe_n"}, oe_n, (rd && ch < 8) ? 1'b0 : 1'b1);
    chk({req, " R4 aerr"}, aerr, exp_aerr);
    if (ch < 8) begin
      chk({req, " R12 act_ps"}, act_ps, ps);
      if (!ext) begin
        for (int j = 1; j <= w; j++) begin
          @(negedge clk); #1;
          chk({req, " R8 ta wait"}, ta, 0);
          chk({req, " R8 cs held"}, cs_n, exp_cs);
        end
        @(negedge clk); #1;
        chk({req, " R8 ta due"}, ta, 1);
        chk({req, " R8 cs release"}, cs_n, 8'hFF);
      end else begin
        for (int j = 0; j < 3; j++) begin
          @(negedge clk); #1;
          chk({req, " R9 ta wait"}, ta, 0);
          chk({req, " R9 cs held"}, cs_n, exp_cs);
        end
        @(negedge clk);
        ext_ack = 1;
        @(negedge clk); #1;
        ext_ack = 0;
        chk({req, " R9 ta after ack"}, ta, 1);
        chk({req, " R9 cs release"}, cs_n, 8'hFF);
      end
    end else begin
      @(negedge clk); #1;
      chk({req, " R10 ta"}, ta, 0);
      chk({req, " R10 aerr over"}, aerr, 0);
      chk({req, " R10 cs"}, cs_n, 8'hFF);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20_000 * 10);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk); #1;
    chk("R5 cs_n reset", cs_n, 8'hFF);
    chk("R5 oe_n reset", oe_n, 1);
    chk("R5 ta reset", ta, 0);
    chk("R5 aerr reset", aerr, 0);
    rd_reg(0, 2, 32'h0F9, "R6 strap captured");
    rd_reg(0, 1, 32'hFFFF_0000, "R5 ch0 mask");
    rd_reg(1, 2, 32'h0, "R5 ch1 ctrl");
    rd_reg(7, 2, 32'h0, "R5 ch7 ctrl");
    access(32'hABCD_0000, 1, 0, 0, 15, 0, 2, "R5 boot access");

    rst_n = 0; cfg_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd_reg(0, 2, 32'h0F1, "R6 no strap");

    wr_reg(0, 0, 32'h0000_0000); wr_reg(0, 1, 32'h00FF_0000);
    wr_reg(0, 2, mk_ctrl(1, 0, 1, 2, 0));
    wr_reg(1, 0, 32'h1000_0000); wr_reg(1, 1, 32'h000F_0000);
    wr_reg(1, 2, mk_ctrl(1, 1, 2, 1, 0));
    wr_reg(2, 0, 32'h1000_0000); wr_reg(2, 1, 32'h00FF_0000);
    wr_reg(2, 2, mk_ctrl(1, 0, 3, 0, 0));
    wr_reg(3, 0, 32'h2000_0000); wr_reg(3, 1, 32'h0);
    wr_reg(3, 2, mk_ctrl(1, 0, 0, 0, 1));
    wr_reg(5, 0, 32'h3000_0000);
    rd_reg(2, 1, 32'h00FF_0000, "R1 mask readback");
    rd_reg(1, 2, 32'h01B, "R1 ctrl readback");
    rd_reg(3, 2, 32'h101, "R1 ext bit readback");
    rd_reg(5, 0, 32'h3000_0000, "R1 base readback");

    for (int v = 0; v < NV; v++)
      access(V_ADDR[v], V_RD[v], V_CH[v], V_AERR[v],
             (V_CH[v] < 8) ? CH_W[V_CH[v]] : 0, 0,
             (V_CH[v] < 8) ? CH_PS[V_CH[v]] : 0, $sformatf("R2 R3 vec%0d", v));

    access(32'h2000_0000, 1, 3, 0, 0, 1, 0, "R9 ext read");
    access(32'h2000_1234, 0, 3, 0, 0, 1, 0, "R9 ext write");
    access(32'h2001_0000, 1, 8, 0, 0, 0, 0, "R2 one bit off");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule